// File: doc/BRIEF.md
# Tapped Binary Divider Chain

This block is a fourteen-stage binary counter that serves as a clock divider and a simple timer. Each high-to-low transition of its clock input advances the count by one. A master clear input, active high, empties every stage the moment it rises, without waiting for any clock edge, and keeps the counter at zero for as long as it stays high.

Only some of the stages drive outputs. Stages 3 to 9 and 11 to 13 appear on a ten-bit tap bus. Stages 0, 1, 2 and 10 stay internal. Stage n toggles at 1/2^(n+1) of the input clock rate, so each tap gives a fixed division ratio. The first high level on a tap is a delay of a known number of clock edges. The block is modelled as a synchronous counter clocked on the falling edge, so there is no skew between stages. A parameter selects how the next count is formed: with a single adder, or with a per-stage toggle chain.

Top module: `tapped_divider`

## Requirements
- R1: While `clear` is high, every tap reads 0. A rise of `clear` in the middle of a count sets all taps to 0 at once, before the next clock edge.
- R2: Each falling edge of `div_clk` with `clear` low adds one to the internal 14-bit count. Rising edges do not change the count.
- R3: While `clear` is held high, falling clock edges have no effect. The taps stay 0 across any number of edges.
- R4: Bit 9 down to bit 0 of `taps` carry stages 13, 12, 11, 9, 8, 7, 6, 5, 4 and 3, in that order. Stages 0, 1, 2 and 10 have no output.
- R5: Counting from zero, tap bit 0 (stage 3) first goes high after 8 falling edges. Tap bit 9 (stage 13) first goes high after 8192 falling edges.
- R6: From the all-ones count (16383), the next falling edge returns the count to 0, so every tap goes low.
- R7: After `clear` falls, the next falling edge is the first one counted, and counting starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| div_clk | input | 1 | Input clock; the count advances on its falling edge |
| clear | input | 1 | Asynchronous master clear, active high, overrides all else |
| taps | output | 10 | Visible stage outputs {s13,s12,s11,s9,s8,s7,s6,s5,s4,s3} |

## Verification
The hardest event to reach from the ports is the wrap from 16383 to 0, together with the first rise of stage 13. Both lie thousands of edges deep, and the low stages they depend on are hidden. The stimulus releases clear and then runs the clock without a break for more than 16384 falling edges. At every rising edge it compares the taps with a falling-edge count kept in the bench. It places explicit checks at counts 8191, 8192, 16383 and 0. The asynchronous clear is raised half a period after a falling edge, and the taps are checked before the next edge can arrive.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;

   localparam int MASK_BITS = 32;

   typedef enum logic {
      CHAIN_ADDER  = 1'b0,
      CHAIN_TOGGLE = 1'b1
   } chain_kind_e;

   function automatic int count_ones(input logic [MASK_BITS-1:0] m);
      int n;
      n = 0;
      for (int i = 0; i < MASK_BITS; i++) begin
         if (m[i]) n++;
      end
      return n;
   endfunction

   // Bus position of stage s: the number of tapped stages below it.
   function automatic int tap_pos(input logic [MASK_BITS-1:0] m, input int s);
      int n;
      n = 0;
      for (int i = 0; i < MASK_BITS; i++) begin
         if (i < s && m[i]) n++;
      end
      return n;
   endfunction

   function automatic int lowest_tap(input logic [MASK_BITS-1:0] m);
      int lo;
      lo = 0;
      for (int i = MASK_BITS - 1; i >= 0; i--) begin
         if (m[i]) lo = i;
      end
      return lo;
   endfunction

endpackage

// File: rtl/tdiv_count_core.sv
module tdiv_count_core
   import tdiv_pkg::*;
#(
   parameter int          STAGES = 14,
   parameter chain_kind_e KIND   = CHAIN_TOGGLE
) (
   input  logic              clk,
   input  logic              clear,
   output logic [STAGES-1:0] count
);

   localparam logic [STAGES-1:0] ALL_ONES = {STAGES{1'b1}};

   generate
      if (STAGES < 2 || STAGES > MASK_BITS) begin : g_bad_stages
         $error("tdiv_count_core: STAGES out of range");
      end

      if (KIND == CHAIN_ADDER) begin : g_adder
         always_ff @(negedge clk or posedge clear) begin
            if (clear) count <= '0;
            else       count <= count + 1'b1;
         end
      end else begin : g_toggle
         logic [STAGES:0]   carry;
         logic [STAGES-1:0] flip;
         assign carry[0] = 1'b1;
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            assign flip[s]    = carry[s];
            assign carry[s+1] = carry[s] & count[s];
         end
         always_ff @(negedge clk or posedge clear) begin
            if (clear) count <= '0;
            else       count <= count ^ flip;
         end
      end
   endgenerate

   // Set by the first counted edge after a clear.
   logic armed;
   always_ff @(negedge clk or posedge clear) begin
      if (clear) armed <= 1'b0;
      else       armed <= 1'b1;
   end

   assert_step_R2: assert property (@(negedge clk) disable iff (clear)
      armed |-> (count == STAGES'($past(count) + 1'b1)));

   assert_wrap_R6: assert property (@(negedge clk) disable iff (clear)
      (armed && $past(count) == ALL_ONES) |-> (count == '0));

   assert_first_R7: assert property (@(negedge clk) disable iff (clear)
      $rose(armed) |-> (count == STAGES'(1)));

   always @(negedge clk) begin
      if (clear) begin
         assert_hold_R3: assert (count == '0);
      end
   end

endmodule

// File: rtl/tdiv_tap_select.sv
module tdiv_tap_select
   import tdiv_pkg::*;
#(
   parameter int                   STAGES   = 14,
   parameter logic [MASK_BITS-1:0] TAP_MASK = 32'h0000_3BF8,
   localparam int                  NTAPS    = count_ones(TAP_MASK)
) (
   input  logic [STAGES-1:0] count,
   output logic [NTAPS-1:0]  taps
);

   localparam logic [MASK_BITS-1:0] STAGE_MASK = MASK_BITS'((64'd1 << STAGES) - 1);

   generate
      if (NTAPS < 1) begin : g_no_taps
         $error("tdiv_tap_select: TAP_MASK selects no stage");
      end
      if ((TAP_MASK & ~STAGE_MASK) != '0) begin : g_mask_range
         $error("tdiv_tap_select: TAP_MASK names a stage that does not exist");
      end

      for (genvar s = 0; s < STAGES; s++) begin : g_sel
         if (TAP_MASK[s]) begin : g_tap
            assign taps[tap_pos(TAP_MASK, s)] = count[s];
         end
      end
   endgenerate

   wire unused_hidden = ^(count & ~TAP_MASK[STAGES-1:0]);

endmodule

// File: rtl/tapped_divider.sv
module tapped_divider
   import tdiv_pkg::*;
#(
   parameter int                   STAGES   = 14,
   parameter logic [MASK_BITS-1:0] TAP_MASK = 32'h0000_3BF8,
   parameter chain_kind_e          KIND     = CHAIN_TOGGLE,
   localparam int                  NTAPS    = count_ones(TAP_MASK)
) (
   input  logic             div_clk,
   input  logic             clear,
   output logic [NTAPS-1:0] taps
);

   localparam int LOW_TAP = lowest_tap(TAP_MASK);

   logic [STAGES-1:0] count;

   tdiv_count_core #(
      .STAGES (STAGES),
      .KIND   (KIND)
   ) u_core (
      .clk   (div_clk),
      .clear (clear),
      .count (count)
   );

   tdiv_tap_select #(
      .STAGES   (STAGES),
      .TAP_MASK (TAP_MASK)
   ) u_taps (
      .count (count),
      .taps  (taps)
   );

   always @(posedge div_clk) begin
      if (clear) begin
         assert_clear_R1: assert (taps == '0);
      end
   end

   // A rise of the lowest tap means all the hidden stages below it have just wrapped.
   generate
      if (LOW_TAP > 0) begin : g_low_chk
         assert_tap_rise_R5: assert property (@(negedge div_clk) disable iff (clear)
            $rose(taps[0]) |-> (count[LOW_TAP-1:0] == '0));
      end
   endgenerate

endmodule

// File: tb/tb_tapped_divider.sv
module tb_tapped_divider;

   localparam int CLK_PERIOD = 10;

   logic       div_clk;
   logic       clear;
   logic [9:0] taps;

   int tests_run  = 0;
   int tests_fail = 0;
   int ref_count  = 0;

   tapped_divider dut (
      .div_clk (div_clk),
      .clear   (clear),
      .taps    (taps)
   );

   initial begin
      div_clk = 1'b1;
      forever #(CLK_PERIOD/2) div_clk = ~div_clk;
   end

   // Reference: falling edges counted since the last clear, modulo 2^14.
   always @(negedge div_clk or posedge clear) begin
      if (clear) ref_count <= 0;
      else       ref_count <= (ref_count + 1) % 16384;
   end

   function automatic logic [9:0] exp_bus(input int c);
      logic [13:0] v;
      v = c[13:0];
      return {v[13], v[12], v[11], v[9], v[8], v[7], v[6], v[5], v[4], v[3]};
   endfunction

   task automatic check_eq(input string req, input logic [9:0] act, input logic [9:0] exp);
      tests_run++;
      if (act !== exp) begin
         tests_fail++;
         $display("FAIL %s: taps actual %b expected %b (ref count %0d)", req, act, exp, ref_count);
      end
   endtask

   task automatic run_edges(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(posedge div_clk); #1;
         check_eq(req, taps, exp_bus(ref_count));
      end
   endtask

   task automatic t_reset_state;
      @(posedge div_clk); #1;
      check_eq("R1 reset state", taps, 10'b0);
   endtask

   task automatic t_release_first;
      // Clock is high here; release, then count 8 falling edges.
      clear = 1'b0;
      for (int k = 1; k <= 8; k++) begin
         @(posedge div_clk); #1;
         check_eq("R7 first edge after release", taps, (k >= 8) ? 10'b0000000001 : 10'b0);
      end
   endtask

   task automatic t_long_run;
      while (ref_count != 8191) run_edges(1, "R2 R4 count compare");
      check_eq("R5 stage13 low at 8191", {9'b0, taps[9]}, 10'b0);
      run_edges(1, "R2 R4 count compare");
      check_eq("R5 stage13 high at 8192", {9'b0, taps[9]}, 10'b1);
      while (ref_count != 16383) run_edges(1, "R2 R4 count compare");
      check_eq("R6 all ones before wrap", taps, 10'h3FF);
      @(posedge div_clk); #1;
      check_eq("R6 wrap to zero", taps, 10'b0);
      run_edges(40, "R2 after wrap");
   endtask

   task automatic t_mid_reset;
      run_edges(100, "R2 before mid clear");
      check_eq("R1 nonzero before clear", (taps != 0) ? 10'b1 : 10'b0, 10'b1);
      @(posedge div_clk); #1;
      clear = 1'b1;
      #1;
      check_eq("R1 async clear mid count", taps, 10'b0);
   endtask

   task automatic t_hold;
      for (int i = 0; i < 12; i++) begin
         @(posedge div_clk); #1;
         check_eq("R3 held clear ignores edges", taps, 10'b0);
      end
   endtask

   task automatic t_release_again;
      t_release_first();
      run_edges(300, "R7 R4 count after second release");
   endtask

   initial begin
      clear = 1'b1;
      t_reset_state();
      t_release_first();
      t_long_run();
      t_mid_reset();
      t_hold();
      t_release_again();
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      tests_run++;
      tests_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
   end

endmodule